// File: doc/BRIEF.md
# Serial Byte-Memory Slave with Write-Enable Latch

This block is the slave side of an SPI link in front of a byte-wide memory array. A host selects it by pulling chip select low, clocks one opcode byte in, and then, depending on the opcode, clocks address and data bytes in or reads status or memory bytes out. Every byte moves most significant bit first. Incoming bits are taken on the rising SCK edge and outgoing bits change on the falling edge, so SCK may idle low or high. The serial pins are oversampled by the block's own system clock, which must run at several times the SCK rate.

Before the host can write, it has to arm a write-enable latch. The latch is shown in the status byte and is disarmed by the disarm opcode or when a write transaction ends. A memory write stores each byte in the array the moment its last bit is received, so the next command can start with no busy or polling phase. A status bit, together with the active-low write-protect pin, can lock the status byte against changes. The array depth is set by a parameter. The address auto-increments and wraps at the top of the array.

Top module: `nvm_spi_slave`

## Requirements
- R1: Opcode byte values are 0x06 arm latch, 0x04 disarm latch, 0x05 read status, 0x01 write status, 0x03 read memory and 0x02 write memory. All bytes travel MSB first.
- R2: SI is sampled on rising SCK and SO changes only after falling SCK. Transfers work with SCK idling low (mode 0) and idling high (mode 3).
- R3: After reset the latch is clear, the status byte reads 0x00 and so_oe is low.
- R4: The arm opcode sets the latch, which reads back as status bit 1. The read-status opcode returns the status byte repeatedly for as long as chip select stays low.
- R5: The disarm opcode clears the latch.
- R6: A status write stores data bits 7, 3 and 2 only. Bit 1 always shows the latch, whatever the data byte carries there, and bits 6, 5, 4 and 0 read 0.
- R7: The latch clears when chip select rises after a memory or status write that moved at least one full data byte. An abort before the first full data byte leaves the latch set.
- R8: Each write-memory data byte is stored as soon as its eighth bit arrives. A trailing partial byte is dropped, and a following command sees the stored data at once.
- R9: Read and write memory take two address bytes, high byte first, and use the low ADDR_W bits (default 11, a 2048-byte array). The address increments after each data byte and wraps from the top address to 0.
- R10: Write-memory and write-status transactions have no effect while the latch is clear.
- R11: Chip select high drops any partial byte, returns the decoder to the opcode phase and pulls so_oe low.
- R12: An unknown opcode is ignored together with every byte that follows it in the same selection. so_oe stays low.
- R13: A status write is ignored while wp_n is low and status bit 7 is set, and the latch then stays set. wp_n has no effect on write-memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for so; the pad is high impedance while low |

## Verification
The bench aims at the cases where a transaction ends at an awkward point. These are: chip select rising mid-byte after data, after a complete address with no data, and inside the opcode byte. A design that counted partial bytes as complete would clear the latch or store a byte too early. A design that kept its bit counter across selections would misread the next opcode. The bench writes across the top of the array and reads back from address 0 to catch a missing wrap. It sends the disarm value as a trailing byte after an unknown opcode, and a design that decoded every byte as a command would drop the latch. It also tries status writes with the latch clear, with bit 1 set in the data, and under write protect. Throughout, random transfers switch between both SCK idle levels, which catches a wrong SO edge or a missing first bit.

// File: rtl/nvm_spi_pkg.sv
package nvm_spi_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    // command byte values
    typedef enum logic [7:0] {
        OP_WRSR  = 8'h01,
        OP_WRITE = 8'h02,
        OP_READ  = 8'h03,
        OP_WRDI  = 8'h04,
        OP_RDSR  = 8'h05,
        OP_WREN  = 8'h06
    } opcode_e;

    // transaction phase of the decoder
    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_WR_DATA,
        PH_RD_DATA,
        PH_SR_WR,
        PH_SR_RD,
        PH_SKIP
    } phase_e;

    // status byte layout
    localparam byte_t SR_WEL_MASK   = 8'h02;
    localparam byte_t SR_STORE_MASK = 8'h8C;
    localparam int    SR_LOCK_BIT   = 7;

    // synchronised serial bus events
    typedef struct packed {
        logic rise;
        logic fall;
        logic sel;
        logic desel;
        logic si;
    } bus_evt_t;

    function automatic byte_t sr_merge(byte_t stored, logic wel);
        return (stored & SR_STORE_MASK) | (wel ? SR_WEL_MASK : byte_t'(0));
    endfunction

    function automatic logic [15:0] join_addr(byte_t hi, byte_t lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/nvm_spi_sampler.sv
module nvm_spi_sampler
    import nvm_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sck,
    input  logic     si,
    output bus_evt_t evt
);

    localparam int TOP = SYNC_STAGES;

    logic [TOP:0] sck_p;
    logic [TOP:0] cs_p;
    logic [TOP:0] si_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            cs_p  <= '1;
            si_p  <= '0;
        end else begin
            sck_p <= {sck_p[TOP-1:0], sck};
            cs_p  <= {cs_p[TOP-1:0], cs_n};
            si_p  <= {si_p[TOP-1:0], si};
        end
    end

    logic sel_now;
    assign sel_now = ~cs_p[TOP-1];

    always_comb begin
        evt.sel   = sel_now;
        evt.rise  = sel_now & sck_p[TOP-1] & ~sck_p[TOP];
        evt.fall  = sel_now & ~sck_p[TOP-1] & sck_p[TOP];
        evt.desel = cs_p[TOP-1] & ~cs_p[TOP];
        evt.si    = si_p[TOP-1] & ~si_p[TOP] | si_p[TOP-1] & si_p[TOP];
    end

endmodule

// File: rtl/nvm_spi_shift.sv
module nvm_spi_shift
    import nvm_spi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel,
    input  logic  rise,
    input  logic  fall,
    input  logic  si,
    input  logic  load_en,
    input  byte_t load_byte,
    output logic  byte_done,
    output byte_t rx_byte,
    output logic  so_bit
);

    logic [CNT_W-1:0] bit_cnt;
    byte_t            rx_sr;
    byte_t            tx_sr;
    logic             so_q;

    assign rx_byte   = {rx_sr[BYTE_W-2:0], si};
    assign byte_done = rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign so_bit    = so_q;

    // receive side: count bits while selected, restart on deselect
    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            rx_sr   <= rx_byte;
        end
    end

    // transmit side: load at a byte boundary, shift on falling SCK
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
            so_q  <= 1'b0;
        end else if (load_en) begin
            tx_sr <= load_byte;
        end else if (fall) begin
            so_q  <= tx_sr[BYTE_W-1];
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
    end

    // R2: the output bit moves only after a falling SCK edge
    a_r2_so_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(so_q) |-> $past(fall));

    // R11: a deselected bus never completes a byte
    a_r11_no_byte_when_idle: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !byte_done || sel);

endmodule

// File: rtl/nvm_spi_array.sv
module nvm_spi_array
    import nvm_spi_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/nvm_spi_ctrl.sv
module nvm_spi_ctrl
    import nvm_spi_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              desel,
    input  logic              byte_done,
    input  byte_t             rx_byte,
    input  logic              wp_n,
    input  byte_t             rd_data,
    output logic              load_en,
    output byte_t             load_byte,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output byte_t             mem_wdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              so_oe
);

    phase_e            phase;
    logic              rd_op;
    byte_t             addr_hi;
    logic [ADDR_W-1:0] addr;
    logic              wel;
    byte_t             sr_store;
    logic              wr_done;

    logic [ADDR_W-1:0] addr_in;
    byte_t             status;
    logic              at_opcode;
    logic              wrdi_hit;
    logic              wren_hit;
    logic              sr_locked;

    assign addr_in   = ADDR_W'(join_addr(addr_hi, rx_byte));
    assign status    = sr_merge(sr_store, wel);
    assign at_opcode = byte_done && (phase == PH_OPCODE);
    assign wrdi_hit  = at_opcode && (rx_byte == OP_WRDI);
    assign wren_hit  = at_opcode && (rx_byte == OP_WREN);
    assign sr_locked = !wp_n && sr_store[SR_LOCK_BIT];

    assign mem_raddr = (phase == PH_ADDR_LO) ? addr_in : addr;
    assign mem_we    = byte_done && (phase == PH_WR_DATA);
    assign mem_waddr = addr;
    assign mem_wdata = rx_byte;
    assign so_oe     = (phase == PH_RD_DATA) || (phase == PH_SR_RD);

    always_comb begin
        load_en   = 1'b0;
        load_byte = rd_data;
        if (byte_done) begin
            unique case (phase)
                PH_OPCODE: begin
                    load_en   = (rx_byte == OP_RDSR);
                    load_byte = status;
                end
                PH_SR_RD: begin
                    load_en   = 1'b1;
                    load_byte = status;
                end
                PH_ADDR_LO: load_en = rd_op;
                PH_RD_DATA: load_en = 1'b1;
                default:    load_en = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_OPCODE;
            rd_op    <= 1'b0;
            addr_hi  <= '0;
            addr     <= '0;
            wel      <= 1'b0;
            sr_store <= '0;
            wr_done  <= 1'b0;
        end else if (!sel) begin
            phase   <= PH_OPCODE;
            wr_done <= 1'b0;
            if (desel && wr_done) begin
                wel <= 1'b0;
            end
        end else if (byte_done) begin
            unique case (phase)
                PH_OPCODE: begin
                    unique case (rx_byte)
                        OP_WREN: begin
                            wel   <= 1'b1;
                            phase <= PH_SKIP;
                        end
                        OP_WRDI: begin
                            wel   <= 1'b0;
                            phase <= PH_SKIP;
                        end
                        OP_RDSR: phase <= PH_SR_RD;
                        OP_WRSR: phase <= (wel && !sr_locked) ? PH_SR_WR : PH_SKIP;
                        OP_READ: begin
                            rd_op <= 1'b1;
                            phase <= PH_ADDR_HI;
                        end
                        OP_WRITE: begin
                            rd_op <= 1'b0;
                            phase <= wel ? PH_ADDR_HI : PH_SKIP;
                        end
                        default: phase <= PH_SKIP;
                    endcase
                end
                PH_ADDR_HI: begin
                    addr_hi <= rx_byte;
                    phase   <= PH_ADDR_LO;
                end
                PH_ADDR_LO: begin
                    addr  <= rd_op ? addr_in + 1'b1 : addr_in;
                    phase <= rd_op ? PH_RD_DATA : PH_WR_DATA;
                end
                PH_WR_DATA: begin
                    addr    <= addr + 1'b1;
                    wr_done <= 1'b1;
                end
                PH_RD_DATA: addr <= addr + 1'b1;
                PH_SR_WR: begin
                    sr_store <= rx_byte & SR_STORE_MASK;
                    wr_done  <= 1'b1;
                    phase    <= PH_SKIP;
                end
                default: phase <= phase;
            endcase
        end
    end

    // R10: the array is written only while the latch is armed
    a_r10_we_needs_wel: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> wel);

    // R4: only the arm opcode can set the latch
    a_r4_wel_set_by_wren: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> $past(wren_hit));

    // R5: the disarm opcode leaves the latch clear
    a_r5_wrdi_clears: assert property (@(posedge clk) disable iff (rst)
        wrdi_hit |=> !wel);

    // R7: the latch falls only on disarm or at the end of a completed write
    a_r7_wel_fall_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(wel) |-> $past(wrdi_hit || (desel && wr_done)));

    // R9: writing the top address wraps the pointer to zero
    a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
        (mem_we && (mem_waddr == '1)) |=> (addr == '0));

    // R11: deselect turns the output driver off
    a_r11_oe_drop: assert property (@(posedge clk) disable iff (rst)
        desel |=> !so_oe);

    // R13: a locked status byte refuses the status write
    a_r13_lock: assert property (@(posedge clk) disable iff (rst)
        (at_opcode && (rx_byte == OP_WRSR) && sr_locked) |=> (phase == PH_SKIP));

endmodule

// File: rtl/nvm_spi_slave.sv
module nvm_spi_slave
    import nvm_spi_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);

    bus_evt_t          evt;
    logic              byte_done;
    byte_t             rx_byte;
    logic              load_en;
    byte_t             load_byte;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    byte_t             mem_wdata;
    logic [ADDR_W-1:0] mem_raddr;
    byte_t             rd_data;

    nvm_spi_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sck  (sck),
        .si   (si),
        .evt  (evt)
    );

    nvm_spi_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .sel       (evt.sel),
        .rise      (evt.rise),
        .fall      (evt.fall),
        .si        (evt.si),
        .load_en   (load_en),
        .load_byte (load_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .so_bit    (so)
    );

    nvm_spi_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sel       (evt.sel),
        .desel     (evt.desel),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .wp_n      (wp_n),
        .rd_data   (rd_data),
        .load_en   (load_en),
        .load_byte (load_byte),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .so_oe     (so_oe)
    );

    nvm_spi_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (rd_data)
    );

endmodule

// File: tb/nvm_spi_slave_test.sv
module nvm_spi_slave_test;
    import nvm_spi_pkg::*;

    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic wp_n = 1'b1;
    logic so;
    logic so_oe;

    nvm_spi_slave #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .wp_n(wp_n), .so(so), .so_oe(so_oe)
    );

    always #2 clk = ~clk;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   mode3 = 1'b0;
    bit   any_oe = 1'b0;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];
    logic [7:0] model [DEPTH];
    bit         known [DEPTH];
    logic [7:0] sr;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic sel_on();
        sck = mode3;
        tick(4);
        cs_n = 1'b0;
        any_oe = 1'b0;
        tick(HALF);
    endtask

    task automatic sel_off();
        tick(HALF);
        cs_n = 1'b1;
        tick(HALF);
        sck = mode3;
        tick(6);
    endtask

    // shifts nb bits of tx, MSB first; returns the bits seen on so
    task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            if (mode3) sck = 1'b0;
            si = tx[i];
            tick(HALF);
            rx[i] = so;
            any_oe = any_oe | so_oe;
            sck = 1'b1;
            tick(HALF);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic do_cmd(input logic [7:0] op);
        logic [7:0] d;
        sel_on();
        xfer(op, d);
        sel_off();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel_on();
        xfer(OP_RDSR, d);
        xfer(8'h00, s);
        sel_off();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        sel_on();
        xfer(OP_WRSR, d);
        xfer(v, d);
        sel_off();
    endtask

    task automatic write_blk(input logic [15:0] a, input int n);
        logic [7:0] d;
        sel_on();
        xfer(OP_WRITE, d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
        for (int k = 0; k < n; k++) xfer(wbuf[k], d);
        sel_off();
    endtask

    task automatic read_blk(input logic [15:0] a, input int n);
        logic [7:0] d;
        sel_on();
        xfer(OP_READ, d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
        for (int k = 0; k < n; k++) xfer(8'h00, rbuf[k]);
        sel_off();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4242));
        tick(10);
        rst = 1'b0;
        tick(4);

        // R3: reset state
        check8("R3 so_oe after reset", {7'd0, so_oe}, 8'h00);
        rdsr(sr);
        check8("R3 status after reset", sr, 8'h00);

        // R4 / R5: arm and disarm
        do_cmd(OP_WREN);
        rdsr(sr);
        check8("R4 status after arm", sr, 8'h02);
        sel_on();
        xfer(OP_RDSR, d);
        xfer(8'h00, d);
        xfer(8'h00, sr);
        sel_off();
        check8("R4 repeated status byte", sr, 8'h02);
        do_cmd(OP_WRDI);
        rdsr(sr);
        check8("R5 status after disarm", sr, 8'h00);

        // R7 / R10 / R8 / R1: basic write, disarm on completion, blocked write
        do_cmd(OP_WREN);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        write_blk(16'h0005, 2);
        rdsr(sr);
        check8("R7 latch cleared after write", sr, 8'h00);
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
        write_blk(16'h0005, 2);
        read_blk(16'h0005, 2);
        check8("R1 R10 byte 0 kept", rbuf[0], 8'h11);
        check8("R10 byte 1 kept", rbuf[1], 8'h22);
        check8("R11 so_oe low after read", {7'd0, so_oe}, 8'h00);

        // R8 / R11: trailing partial byte dropped
        do_cmd(OP_WREN);
        wbuf[0] = 8'h77;
        write_blk(16'h0102, 1);
        do_cmd(OP_WREN);
        sel_on();
        xfer(OP_WRITE, d); xfer(8'h01, d); xfer(8'h00, d);
        xfer(8'hC3, d); xfer(8'h3C, d);
        xfer_bits(8'hFF, 5, d);
        sel_off();
        read_blk(16'h0100, 3);
        check8("R8 first byte stored", rbuf[0], 8'hC3);
        check8("R8 second byte stored", rbuf[1], 8'h3C);
        check8("R8 R11 partial byte dropped", rbuf[2], 8'h77);
        rdsr(sr);
        check8("R7 latch cleared after partial tail", sr, 8'h00);

        // R7: aborts before a full data byte keep the latch
        do_cmd(OP_WREN);
        sel_on();
        xfer(OP_WRITE, d); xfer(8'h01, d);
        xfer_bits(8'h00, 5, d);
        sel_off();
        rdsr(sr);
        check8("R7 abort in address keeps latch", sr, 8'h02);
        sel_on();
        xfer(OP_WRITE, d); xfer(8'h01, d); xfer(8'h00, d);
        sel_off();
        rdsr(sr);
        check8("R7 no data byte keeps latch", sr, 8'h02);

        // R11: partial opcode aborted
        sel_on();
        xfer_bits(OP_WRDI, 3, d);
        sel_off();
        rdsr(sr);
        check8("R11 partial opcode ignored", sr, 8'h02);

        // R12: unknown opcode and its trailing bytes ignored
        sel_on();
        xfer(8'hA5, d); xfer(OP_WRDI, d); xfer(8'h00, d);
        sel_off();
        check8("R12 so_oe stayed low", {7'd0, any_oe}, 8'h00);
        rdsr(sr);
        check8("R12 latch unchanged", sr, 8'h02);
        do_cmd(OP_WRDI);

        // R9: wrap and ignored high address bits
        do_cmd(OP_WREN);
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
        write_blk(16'h07FE, 4);
        read_blk(16'h07FE, 4);
        check8("R9 top-1", rbuf[0], 8'h01);
        check8("R9 top", rbuf[1], 8'h02);
        check8("R9 wrapped read", rbuf[2], 8'h03);
        read_blk(16'h0000, 2);
        check8("R9 wrapped write addr 0", rbuf[0], 8'h03);
        check8("R9 wrapped write addr 1", rbuf[1], 8'h04);
        read_blk(16'hF800, 1);
        check8("R9 high address bits ignored", rbuf[0], 8'h03);

        // R6 / R13: status byte
        do_cmd(OP_WREN);
        wrsr(8'hFF);
        rdsr(sr);
        check8("R6 stored bits only", sr, 8'h8C);
        do_cmd(OP_WREN);
        rdsr(sr);
        check8("R6 latch visible with stored bits", sr, 8'h8E);
        wp_n = 1'b0;
        wrsr(8'h00);
        rdsr(sr);
        check8("R13 locked status write ignored", sr, 8'h8E);
        wbuf[0] = 8'h5E;
        write_blk(16'h0200, 1);
        read_blk(16'h0200, 1);
        check8("R13 write-memory unaffected by pin", rbuf[0], 8'h5E);
        wp_n = 1'b1;
        do_cmd(OP_WREN);
        wrsr(8'h02);
        rdsr(sr);
        check8("R6 data bit 1 not stored", sr, 8'h00);
        wrsr(8'hFF);
        rdsr(sr);
        check8("R10 status write without latch", sr, 8'h00);

        // R2: SCK idling high
        mode3 = 1'b1;
        rdsr(sr);
        check8("R2 mode 3 status", sr, 8'h00);
        do_cmd(OP_WREN);
        wbuf[0] = 8'h9A; wbuf[1] = 8'hB4;
        write_blk(16'h0300, 2);
        read_blk(16'h0300, 2);
        check8("R2 mode 3 byte 0", rbuf[0], 8'h9A);
        check8("R2 mode 3 byte 1", rbuf[1], 8'hB4);

        // random transfers in both modes
        for (int it = 0; it < 30; it++) begin
            logic [15:0] a;
            int n;
            bit en;
            mode3 = 1'($urandom_range(0, 1));
            a = 16'($urandom);
            n = $urandom_range(1, 6);
            en = ($urandom_range(0, 3) != 0);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            if (en) do_cmd(OP_WREN);
            write_blk(a, n);
            if (en) begin
                for (int k = 0; k < n; k++) begin
                    model[(int'(a[AW-1:0]) + k) % DEPTH] = wbuf[k];
                    known[(int'(a[AW-1:0]) + k) % DEPTH] = 1'b1;
                end
            end
            rdsr(sr);
            check8("R7 status after random write", sr, 8'h00);
            read_blk(a, n);
            for (int k = 0; k < n; k++) begin
                if (known[(int'(a[AW-1:0]) + k) % DEPTH])
                    check8("R2 R9 R10 random readback", rbuf[k],
                           model[(int'(a[AW-1:0]) + k) % DEPTH]);
            end
        end

        report();
        $finish;
    end

endmodule